// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit channels between time-division multiplexed streams. Every channel slot, one byte arrives on each input stream, and the block stores all of them in a data memory that holds two frames: one being written, one being read. Each output channel (one stream, one slot) owns a 13-bit control word in a connection memory. The word either names an input stream and channel whose byte from the previous frame is to be sent, or it carries a literal byte that is sent unchanged in every frame. Several output channels may name the same source, which copies one input channel to many outputs.

The serial line is abstracted. A one-cycle `slot_en` pulse marks each channel slot boundary. At that edge the block captures the input bytes of the slot and presents the output bytes of the same slot. It fetches the output bytes one cycle after the previous boundary. A host port reads and writes a small mode register and, depending on a memory-select bit, either the data memory (read-only) or the connection memory. A per-channel enable and two global controls decide whether each output stream drives. The global controls are an input pin and a standby bit in the mode register. The delay-select and loop bits of the control word are stored and can be read back, but nothing else acts on them.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `tx_drive` is 0, `tx_bytes` is 0, `tx_chan` is 0, and the mode register (host address 0x80) reads 0.
- R2: In connection mode (control word bit 11 clear), output channel c of stream s in frame F+1 carries the byte received in frame F on the stream given by word bits 6:5 and the channel given by word bits 4:0.
- R3: In message mode (bit 11 set), the output carries word bits 7:0 in every frame until the host rewrites the word.
- R4: Any number of output channels may name the same source, and each of them carries that source's byte.
- R5: When bit 12 (drive enable) of a channel's word is clear, `tx_drive` for that stream is low and `tx_bytes` for that stream is 0 for that whole slot.
- R6: A low `drive_allow` input, or a clear mode register bit 1 (standby release), forces every `tx_drive` bit low and every output byte to 0, whatever the per-channel enables are.
- R7: Host address bit 7 set selects the mode register; clear selects a memory at address {stream[6:5], channel[4:0]}. Mode bit 0 set selects the connection memory (13-bit read and write). Clear selects the data memory, which returns the byte of the last complete frame and ignores writes.
- R8: Word bit 10 appears on `tx_ctl` for that stream during the slot whatever the drive state is. Bits 9 and 8 read back as written and have no effect on any output.
- R9: Outputs change only at `slot_en` edges. A host write to a word takes effect from that channel's next fetch. It never alters a byte being output or one already fetched.
- R10: `tx_chan` names the slot on the outputs. It advances by one on each `slot_en` from 0 after reset and wraps after NCHAN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Channel slot boundary pulse (at least 2 cycles apart) |
| rx_bytes | input | NSTREAM*8 | Input byte of each stream for the current slot |
| drive_allow | input | 1 | Global output permission, low forces all outputs off |
| cpu_en | input | 1 | Host access strobe |
| cpu_we | input | 1 | Host write when set with `cpu_en` |
| cpu_addr | input | 8 | Host address: bit 7 mode register, else {stream, channel} |
| cpu_wdata | input | 13 | Host write data |
| cpu_rdata | output | 13 | Host read data (combinational) |
| tx_bytes | output | NSTREAM*8 | Output byte of each stream, 0 when not driving |
| tx_drive | output | NSTREAM | Output stream drive enable for the current slot |
| tx_ctl | output | NSTREAM | Per-channel control output bit |
| tx_chan | output | 5 | Channel slot currently on the outputs |

## Verification
On every cycle the assertions check the global overrides: an output that is not driving carries a zero byte. They also check that outputs and `tx_chan` hold between slot pulses, and that `tx_chan` steps by one at each pulse. The bench scenarios cover the rest, because a reference model has to follow data across frames. They show the one-frame delay of switched data, message bytes repeating, copies to many outputs, and host writes taking effect on the next fetch rather than the current slot. They also show that data-memory writes are ignored and that the stored delay and loop bits do nothing.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int BYTE_W = 8;

    // Control word layout, high bit first
    typedef struct packed {
        logic              drive;   // 12
        logic              msg;     // 11
        logic              ctl;     // 10
        logic              loop;    // 9 stored only
        logic              vdelay;  // 8 stored only
        logic [BYTE_W-1:0] low;     // message byte or {stream, channel}
    } conn_word_t;

    localparam int CW_W = $bits(conn_word_t);

    // Fields the output fetch needs
    typedef struct packed {
        logic              drive;
        logic              msg;
        logic              ctl;
        logic [BYTE_W-1:0] low;
    } fetch_t;

    localparam int FT_W = $bits(fetch_t);

    function automatic fetch_t to_fetch(conn_word_t w);
        fetch_t f;
        f.drive = w.drive;
        f.msg   = w.msg;
        f.ctl   = w.ctl;
        f.low   = w.low;
        return f;
    endfunction
endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer #(
    parameter int NCHAN = 32,
    localparam int CH_W = $clog2(NCHAN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_en,
    output logic [CH_W-1:0] slot,
    output logic            bank,
    output logic            fetch_go
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= '0;
            bank     <= 1'b0;
            fetch_go <= 1'b1;
        end else begin
            fetch_go <= slot_en;
            if (slot_en) begin
                if (slot == CH_W'(NCHAN - 1)) begin
                    slot <= '0;
                    bank <= ~bank;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
    parameter int NSTREAM = 4,
    parameter int NCHAN   = 32,
    localparam int CH_W   = $clog2(NCHAN),
    localparam int ST_W   = $clog2(NSTREAM),
    localparam int AW     = ST_W + CH_W,
    localparam int DEPTH  = NSTREAM * NCHAN
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic                          wr_bank,
    input  logic [CH_W-1:0]               wr_chan,
    input  logic [NSTREAM*tsi_pkg::BYTE_W-1:0] wr_data,
    input  logic                          rd_bank,
    input  logic [NSTREAM*AW-1:0]         rd_addr,
    output logic [NSTREAM*tsi_pkg::BYTE_W-1:0] rd_data,
    input  logic [AW-1:0]                 host_addr,
    output logic [tsi_pkg::BYTE_W-1:0]    host_data
);
    import tsi_pkg::*;

    logic [BYTE_W-1:0] mem [2][DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int s = 0; s < NSTREAM; s++) begin
                mem[wr_bank][{ST_W'(s), wr_chan}] <= wr_data[s*BYTE_W +: BYTE_W];
            end
        end
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_rd
        assign rd_data[s*BYTE_W +: BYTE_W] = mem[rd_bank][rd_addr[s*AW +: AW]];
    end

    assign host_data = mem[rd_bank][host_addr];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter int NSTREAM = 4,
    parameter int NCHAN   = 32,
    localparam int CH_W   = $clog2(NCHAN),
    localparam int ST_W   = $clog2(NSTREAM),
    localparam int AW     = ST_W + CH_W,
    localparam int DEPTH  = NSTREAM * NCHAN
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             host_we,
    input  logic [AW-1:0]                    host_addr,
    input  tsi_pkg::conn_word_t              host_wdata,
    output tsi_pkg::conn_word_t              host_rdata,
    input  logic [CH_W-1:0]                  rd_chan,
    output logic [NSTREAM*tsi_pkg::FT_W-1:0] rd_fetch
);
    import tsi_pkg::*;

    conn_word_t words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (host_we) begin
            words[host_addr] <= host_wdata;
        end
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_rd
        assign rd_fetch[s*FT_W +: FT_W] = to_fetch(words[{ST_W'(s), rd_chan}]);
    end

    assign host_rdata = words[host_addr];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int NSTREAM = 4,
    parameter int NCHAN   = 32,
    localparam int CH_W   = $clog2(NCHAN),
    localparam int ST_W   = $clog2(NSTREAM),
    localparam int AW     = ST_W + CH_W,   // must not exceed 8
    localparam int HA_W   = AW + 1,
    localparam int BW     = tsi_pkg::BYTE_W,
    localparam int DW     = tsi_pkg::CW_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  slot_en,
    input  logic [NSTREAM*BW-1:0] rx_bytes,
    input  logic                  drive_allow,
    input  logic                  cpu_en,
    input  logic                  cpu_we,
    input  logic [HA_W-1:0]       cpu_addr,
    input  logic [DW-1:0]         cpu_wdata,
    output logic [DW-1:0]         cpu_rdata,
    output logic [NSTREAM*BW-1:0] tx_bytes,
    output logic [NSTREAM-1:0]    tx_drive,
    output logic [NSTREAM-1:0]    tx_ctl,
    output logic [CH_W-1:0]       tx_chan
);
    import tsi_pkg::*;

    logic [CH_W-1:0] slot;
    logic            bank;
    logic            fetch_go;

    logic msel_q, standby_on;
    logic mode_hit, mode_wr, cm_wr;

    logic [NSTREAM*FT_W-1:0] cm_fetch;
    logic [NSTREAM*AW-1:0]   src_addr;
    logic [NSTREAM*BW-1:0]   dm_rd, nx_byte;
    logic [NSTREAM-1:0]      nx_drive, nx_ctl;
    conn_word_t              cm_host;
    logic [BW-1:0]           dm_host;

    logic [NSTREAM*BW-1:0]   pre_byte, out_byte;
    logic [NSTREAM-1:0]      pre_drive, pre_ctl, out_drive;

    tsi_slot_timer #(.NCHAN(NCHAN)) u_timer (
        .clk(clk), .rst(rst), .slot_en(slot_en),
        .slot(slot), .bank(bank), .fetch_go(fetch_go)
    );

    tsi_data_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_dmem (
        .clk(clk), .wr_en(slot_en), .wr_bank(bank), .wr_chan(slot),
        .wr_data(rx_bytes), .rd_bank(~bank), .rd_addr(src_addr),
        .rd_data(dm_rd), .host_addr(cpu_addr[AW-1:0]), .host_data(dm_host)
    );

    tsi_conn_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_cmem (
        .clk(clk), .rst(rst), .host_we(cm_wr),
        .host_addr(cpu_addr[AW-1:0]), .host_wdata(conn_word_t'(cpu_wdata)),
        .host_rdata(cm_host), .rd_chan(slot), .rd_fetch(cm_fetch)
    );

    // Host decode
    assign mode_hit = cpu_addr[HA_W-1];
    assign mode_wr  = cpu_en && cpu_we && mode_hit;
    assign cm_wr    = cpu_en && cpu_we && !mode_hit && msel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            msel_q     <= 1'b0;
            standby_on <= 1'b0;
        end else if (mode_wr) begin
            msel_q     <= cpu_wdata[0];
            standby_on <= cpu_wdata[1];
        end
    end

    always_comb begin
        if (mode_hit)    cpu_rdata = {{(DW-2){1'b0}}, standby_on, msel_q};
        else if (msel_q) cpu_rdata = cm_host;
        else             cpu_rdata = {{(DW-BW){1'b0}}, dm_host};
    end

    // Per-stream source selection for the next slot
    for (genvar s = 0; s < NSTREAM; s++) begin : g_fetch
        fetch_t fw;
        assign fw = fetch_t'(cm_fetch[s*FT_W +: FT_W]);
        assign src_addr[s*AW +: AW] = fw.low[AW-1:0];
        assign nx_byte[s*BW +: BW]  = fw.msg ? fw.low : dm_rd[s*BW +: BW];
        assign nx_drive[s]          = fw.drive;
        assign nx_ctl[s]            = fw.ctl;
    end

    // Fetch stage one cycle after a boundary, output stage at the boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_byte  <= '0;
            pre_drive <= '0;
            pre_ctl   <= '0;
            out_byte  <= '0;
            out_drive <= '0;
            tx_ctl    <= '0;
            tx_chan   <= '0;
        end else begin
            if (fetch_go) begin
                pre_byte  <= nx_byte;
                pre_drive <= nx_drive;
                pre_ctl   <= nx_ctl;
            end
            if (slot_en) begin
                out_byte  <= pre_byte;
                out_drive <= pre_drive;
                tx_ctl    <= pre_ctl;
                tx_chan   <= slot;
            end
        end
    end

    assign tx_drive = out_drive & {NSTREAM{drive_allow & standby_on}};

    for (genvar s = 0; s < NSTREAM; s++) begin : g_out
        assign tx_bytes[s*BW +: BW] = tx_drive[s] ? out_byte[s*BW +: BW] : '0;
    end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int NSTREAM = 4,
    parameter int NCHAN   = 32,
    localparam int CH_W   = $clog2(NCHAN)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   slot_en,
    input logic                   drive_allow,
    input logic                   standby_on,
    input logic [NSTREAM*8-1:0]   tx_bytes,
    input logic [NSTREAM-1:0]     tx_drive,
    input logic [NSTREAM-1:0]     tx_ctl,
    input logic [CH_W-1:0]        tx_chan
);
    logic started;

    always_ff @(posedge clk) begin
        if (rst)          started <= 1'b0;
        else if (slot_en) started <= 1'b1;
    end

    // R6
    pin_override_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_allow |-> (tx_drive == '0));

    // R6
    standby_override_chk: assert property (@(posedge clk) disable iff (rst)
        !standby_on |-> (tx_drive == '0));

    for (genvar s = 0; s < NSTREAM; s++) begin : g_quiet
        // R5
        quiet_byte_chk: assert property (@(posedge clk) disable iff (rst)
            !tx_drive[s] |-> (tx_bytes[s*8 +: 8] == 8'h00));
    end

    // R9
    hold_between_slots_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> ($stable(tx_ctl) && $stable(tx_chan)));

    // R10
    chan_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_en && started) |=> (tx_chan == CH_W'($past(tx_chan) + 1'b1)));
endmodule

bind tsi_switch tsi_switch_chk #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_chk (
    .clk(clk), .rst(rst), .slot_en(slot_en), .drive_allow(drive_allow),
    .standby_on(standby_on), .tx_bytes(tx_bytes), .tx_drive(tx_drive),
    .tx_ctl(tx_ctl), .tx_chan(tx_chan)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
    localparam int NS = 4;
    localparam int NC = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic          slot_en = 1'b0;
    logic [NS*8-1:0] rx_bytes = '0;
    logic          drive_allow = 1'b1;
    logic          cpu_en = 1'b0;
    logic          cpu_we = 1'b0;
    logic [7:0]    cpu_addr = '0;
    logic [12:0]   cpu_wdata = '0;
    logic [12:0]   cpu_rdata;
    logic [NS*8-1:0] tx_bytes;
    logic [NS-1:0] tx_drive;
    logic [NS-1:0] tx_ctl;
    logic [4:0]    tx_chan;

    tsi_switch u_dut (
        .clk(clk), .rst(rst), .slot_en(slot_en), .rx_bytes(rx_bytes),
        .drive_allow(drive_allow), .cpu_en(cpu_en), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tx_bytes(tx_bytes), .tx_drive(tx_drive), .tx_ctl(tx_ctl), .tx_chan(tx_chan)
    );

    int checks = 0;
    int fails  = 0;
    int fr     = 0;
    logic [12:0] model [NS*NC];
    logic standby_m = 1'b0;
    int hook_at = -1;
    logic [12:0] pend10, pend11;

    function automatic logic [7:0] pat(int f, int s, int c);
        return 8'(f * 29 + s * 71 + c * 13 + 7);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(logic [7:0] a, logic [12:0] d);
        @(negedge clk);
        cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_en = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(logic [7:0] a, output logic [12:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic set_mode(logic standby, logic msel);
        cpu_write(8'h80, {11'd0, standby, msel});
        standby_m = standby;
    endtask

    task automatic cm_set(int s, int c, logic [12:0] w);
        cpu_write({1'b0, 2'(s), 5'(c)}, w);
        model[s*NC + c] = w;
    endtask

    task automatic check_slot(int c, string req);
        chk("R10", "tx_chan", int'(tx_chan), c);
        for (int s = 0; s < NS; s++) begin
            logic [12:0] w;
            logic drv;
            logic [7:0] eb;
            w   = model[s*NC + c];
            drv = w[12] & drive_allow & standby_m;
            eb  = !drv ? 8'h00 : (w[11] ? w[7:0] : pat(fr - 1, int'(w[6:5]), int'(w[4:0])));
            chk(req, $sformatf("drive s%0d c%0d", s, c), int'(tx_drive[s]), int'(drv));
            chk(req, $sformatf("byte s%0d c%0d", s, c), int'(tx_bytes[s*8 +: 8]), int'(eb));
            chk("R8", $sformatf("ctl s%0d c%0d", s, c), int'(tx_ctl[s]), int'(w[10]));
        end
    endtask

    task automatic r9_hook();
        logic [7:0] cur;
        cur = tx_bytes[7:0];
        pend10 = 13'h1800 | 13'h0A1;
        pend11 = 13'h1800 | 13'h0B2;
        cpu_write({1'b0, 2'd0, 5'd10}, pend10);
        cpu_write({1'b0, 2'd0, 5'd11}, pend11);
        cm_set(0, 12, 13'h1800 | 13'h0C3);
        @(negedge clk);
        chk("R9", "byte on air after write", int'(tx_bytes[7:0]), int'(cur));
        chk("R9", "slot unchanged", int'(tx_chan), 10);
    endtask

    task automatic run_frame(bit check, string req);
        for (int c = 0; c < NC; c++) begin
            @(negedge clk);
            for (int s = 0; s < NS; s++) rx_bytes[s*8 +: 8] = pat(fr, s, c);
            slot_en = 1'b1;
            @(negedge clk);
            slot_en = 1'b0;
            if (check) check_slot(c, req);
            @(negedge clk);
            if (c == hook_at) r9_hook();
        end
        if (hook_at >= 0) begin
            model[10] = pend10;
            model[11] = pend11;
            hook_at = -1;
        end
        fr++;
    endtask

    task automatic t_reset();
        logic [12:0] d;
        chk("R1", "tx_drive", int'(tx_drive), 0);
        chk("R1", "tx_bytes", int'(tx_bytes), 0);
        chk("R1", "tx_chan", int'(tx_chan), 0);
        cpu_read(8'h80, d);
        chk("R1", "mode reg", int'(d), 0);
    endtask

    task automatic t_connect();
        set_mode(1'b1, 1'b1);
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cm_set(s, c, {1'b1, 4'b0000, 1'b0, 2'((s + 1) % NS), 5'((c * 7 + 3) % NC)});
        run_frame(1'b0, "R2");
        run_frame(1'b1, "R2");
        run_frame(1'b1, "R2");
    endtask

    task automatic t_message();
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c += 2)
                cm_set(s, c, {1'b1, 1'b1, 3'b000, 8'(c * 9 + s)});
        run_frame(1'b0, "R3");
        run_frame(1'b1, "R3");
        run_frame(1'b1, "R3");
    endtask

    task automatic t_broadcast();
        for (int c = 0; c < NC; c++) cm_set(2, c, 13'h1000 | {6'd0, 2'd1, 5'd9});
        cm_set(0, 5, 13'h1000 | {6'd0, 2'd1, 5'd9});
        cm_set(3, 31, 13'h1000 | {6'd0, 2'd1, 5'd9});
        run_frame(1'b0, "R4");
        run_frame(1'b1, "R4");
    endtask

    task automatic t_enable_ctl();
        for (int c = 0; c < NC; c += 3) cm_set(1, c, model[NC + c] & 13'h0FFF);
        for (int c = 1; c < NC; c += 4) cm_set(3, c, model[3*NC + c] | 13'h0700);
        for (int c = 0; c < NC; c += 5) cm_set(0, c, model[c] | 13'h0300);
        run_frame(1'b0, "R5");
        run_frame(1'b1, "R5");
    endtask

    task automatic t_global();
        drive_allow = 1'b0;
        run_frame(1'b1, "R6");
        drive_allow = 1'b1;
        set_mode(1'b0, 1'b1);
        run_frame(1'b1, "R6");
        set_mode(1'b1, 1'b1);
        run_frame(1'b1, "R6");
    endtask

    task automatic t_host();
        logic [12:0] d;
        cpu_read({1'b0, 2'd3, 5'd1}, d);
        chk("R7", "cm readback s3c1", int'(d), int'(model[3*NC + 1]));
        cpu_read({1'b0, 2'd0, 5'd5}, d);
        chk("R8", "stored loop/delay bits s0c5", int'(d[9:8]), int'(model[5][9:8]));
        set_mode(1'b1, 1'b0);
        cpu_read(8'h80, d);
        chk("R7", "mode reg", int'(d), 2);
        for (int i = 0; i < 4; i++) begin
            cpu_read({1'b0, 2'(i), 5'(i * 9)}, d);
            chk("R7", "data mem read", int'(d), int'(pat(fr - 1, i, i * 9)));
        end
        cpu_write({1'b0, 2'd2, 5'd4}, 13'h0055);
        cpu_read({1'b0, 2'd2, 5'd4}, d);
        chk("R7", "data mem write ignored", int'(d), int'(pat(fr - 1, 2, 4)));
        run_frame(1'b1, "R7");
        set_mode(1'b1, 1'b1);
        cpu_read({1'b0, 2'd2, 5'd4}, d);
        chk("R7", "cm untouched by data write", int'(d), int'(model[2*NC + 4]));
    endtask

    task automatic t_timing();
        for (int c = 10; c <= 12; c++) cm_set(0, c, 13'h1000 | {6'd0, 2'd3, 5'(c)});
        run_frame(1'b0, "R9");
        hook_at = 10;
        run_frame(1'b1, "R9");
        run_frame(1'b1, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS*NC; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_connect();
        t_message();
        t_broadcast();
        t_enable_ctl();
        t_global();
        t_host();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule